// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block serialises one low-speed USB packet onto the D+ and D− lines. It runs from a 12 MHz clock and holds every line symbol for eight clocks, which gives 1.5 Mb/s. A request is taken with `start` while the block is idle. The block first parks the lines in the J state and then enables the drivers. It sends a sync byte that it generates itself, followed by the payload bytes LSb first, with NRZI coding and bit stuffing. It closes with the end-of-packet sequence and then releases the bus.

Payload bytes come from an external buffer through a read strobe. The data is registered there and becomes valid one cycle after the strobe. For handshake replies a shortcut is available: with `hs_sel` raised at start, the packet is the sync byte plus the single `hs_pid` byte, and the buffer is not touched. When a data packet (not a handshake) finishes, the pending device address is copied into the active address register. CRC generation and packet assembly belong to the caller.

Top module: `usb_ls_tx`

## Requirements
- R1: After reset, `usb_oe`, `usb_dp`, `usb_dm`, `busy`, `done` and `rd_en` are all 0 and `dev_addr` is 0.
- R2: A `start` seen at a clock edge while idle is accepted. In the next cycle the lines show J (`usb_dp`=0, `usb_dm`=1) with `usb_oe`=0. In the eight cycles after that, J is driven with `usb_oe`=1.
- R3: The first byte on the line is the sync byte 0x80, giving the symbols K J K J K J K K. Each symbol is held for BIT_CLKS cycles. The first K appears in the tenth cycle after the accepting edge, well inside the 60-clock reply window.
- R4: Bytes go out LSb first with NRZI coding: a 0 bit toggles the line, a 1 bit keeps it. J is `usb_dp`=0/`usb_dm`=1 and K is `usb_dp`=1/`usb_dm`=0. The two lines are never both 1.
- R5: After six consecutive 1 bits, one extra toggling symbol is inserted and the run count restarts. The count starts at zero with the sync byte and carries across byte boundaries. A run of six that ends the packet is also followed by a stuffed symbol.
- R6: End of packet is SE0 (both lines 0, `usb_oe`=1) for 16 cycles, then J for 8 cycles. In the following cycle `usb_oe`=0, both lines are 0 and `done`=1 for exactly that one cycle.
- R7: `byte_count` counts the sync byte. A data packet reads `byte_count`−1 bytes (0 treated as 1), each with a one-cycle `rd_en`. `rd_data` is taken in the cycle after the strobe, and the bytes are sent in read order.
- R8: With `hs_sel`=1 at acceptance, the packet is sync plus `hs_pid`. `byte_count` is ignored and `rd_en` stays 0.
- R9: In the `done` cycle of a data packet, `dev_addr` equals the `pend_addr` present at the final edge. After a handshake packet it is unchanged.
- R10: `busy` is 1 from the cycle after acceptance until the `done` cycle, where it is 0. A `start` while busy leaves the packet on the line unchanged.
- R11: A `start` given in the `done` cycle is accepted at once, and the next packet follows with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz clock |
| rst_n | input | 1 | synchronous active-low reset |
| start | input | 1 | request to send a packet (taken while idle) |
| hs_sel | input | 1 | 1 = handshake packet built from `hs_pid` |
| hs_pid | input | 8 | PID byte for a handshake packet |
| byte_count | input | CNT_W | bytes in a data packet, sync byte included |
| rd_en | output | 1 | buffer read strobe, one per payload byte |
| rd_data | input | 8 | buffer byte, valid the cycle after `rd_en` |
| pend_addr | input | ADDR_W | device address waiting to be committed |
| dev_addr | output | ADDR_W | active device address |
| usb_dp | output | 1 | D+ line value |
| usb_dm | output | 1 | D− line value |
| usb_oe | output | 1 | line driver enable |
| busy | output | 1 | packet in progress |
| done | output | 1 | one-cycle pulse when the bus is released |

## Verification
Two events can land on the same bit. One is a stuffed symbol that falls right at a byte boundary, where the next byte is loaded. The bench provokes this with all-ones payloads, in which the run of ones crosses from one byte into the next, and with a byte whose last six bits are ones. The other collision is a bus release, with its `done` pulse and address commit, in the same cycle as a new `start`. The bench issues the second request exactly in the `done` cycle. In both cases a behavioural reference built from byte queues predicts every cycle's line, enable, busy and done values, and the comparison is made on every clock.

// File: rtl/usb_ls_tx_pkg.sv
// Shared types and constants for the low-speed packet transmitter.
package usb_ls_tx_pkg;

    // Sequencer phases of one packet.
    typedef enum logic [2:0] {
        ST_IDLE,   // bus released
        ST_PREP,   // lines parked at J, drivers still off
        ST_LEAD,   // drivers on, J for one bit
        ST_DATA,   // coded symbols
        ST_SE0,    // end-of-packet, both lines low
        ST_EOPJ    // end-of-packet, trailing J
    } tx_state_e;

    // Sync byte as sent LSb first: seven zeros then a one.
    localparam logic [7:0] SYNC_BYTE = 8'h80;

    // Consecutive ones that force a stuffed symbol.
    localparam int STUFF_RUN = 6;

endpackage

// File: rtl/usb_ls_bit_timer.sv
// Bit-period timer.
// Counts clocks while 'run' is high and flags the last clock of each
// symbol. Assumes BIT_CLKS >= 2. Clears whenever 'run' is low, so each
// phase that starts after a cleared period begins on a fresh symbol.
module usb_ls_bit_timer #(
    parameter int BIT_CLKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (BIT_CLKS > 2) ? $clog2(BIT_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(BIT_CLKS - 1);

    logic [CW-1:0] cnt;

    // Clock counter within the current symbol, wrapping at the bit length.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

endmodule

// File: rtl/usb_ls_byte_feed.sv
// Byte feeder and bit serialiser.
// Starts every packet with the sync byte and then presents payload bits
// LSb first. The next byte is fetched from the buffer (one-cycle read
// latency) while bit 0 of the current byte is being consumed. In handshake
// mode the single PID byte is preloaded and the buffer is never read.
module usb_ls_byte_feed
    import usb_ls_tx_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             hs_mode,
    input  logic [7:0]       hs_pid,
    input  logic [CNT_W-1:0] byte_count,
    input  logic             consume,
    input  logic [7:0]       rd_data,
    output logic             cur_bit,
    output logic             have_bits,
    output logic             rd_en
);
    logic [7:0]       cur_q;
    logic [7:0]       nxt_q;
    logic [2:0]       bit_idx;
    logic [CNT_W-1:0] bytes_rem;
    logic             hs_q;
    logic             fetch_pend;

    // Shift register, byte bookkeeping and buffer fetch sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q      <= '0;
            nxt_q      <= '0;
            bit_idx    <= '0;
            bytes_rem  <= '0;
            hs_q       <= 1'b0;
            fetch_pend <= 1'b0;
            have_bits  <= 1'b0;
            rd_en      <= 1'b0;
        end else if (load) begin
            cur_q      <= SYNC_BYTE;
            bit_idx    <= '0;
            have_bits  <= 1'b1;
            hs_q       <= hs_mode;
            fetch_pend <= 1'b0;
            rd_en      <= 1'b0;
            if (hs_mode) begin
                bytes_rem <= CNT_W'(1);
                nxt_q     <= hs_pid;
            end else begin
                bytes_rem <= (byte_count == '0) ? '0 : byte_count - CNT_W'(1);
            end
        end else begin
            rd_en      <= consume && (bit_idx == 3'd0) && (bytes_rem != '0) && !hs_q;
            fetch_pend <= rd_en;
            if (fetch_pend) begin
                nxt_q <= rd_data;
            end
            if (consume) begin
                if (bit_idx == 3'd7) begin
                    bit_idx <= '0;
                    if (bytes_rem != '0) begin
                        cur_q     <= nxt_q;
                        bytes_rem <= bytes_rem - CNT_W'(1);
                    end else begin
                        have_bits <= 1'b0;
                    end
                end else begin
                    cur_q   <= {1'b0, cur_q[7:1]};
                    bit_idx <= bit_idx + 3'd1;
                end
            end
        end
    end

    assign cur_bit = cur_q[0];

endmodule

// File: rtl/usb_ls_nrzi_stuff.sv
// NRZI line coder with bit stuffing.
// Holds the line state (1 = J, 0 = K). Each 'step' emits one symbol:
// a stuffed toggle when six ones have been sent in a row, otherwise the
// coded data bit, which is then reported as consumed.
module usb_ls_nrzi_stuff
    import usb_ls_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic step,
    input  logic data_bit,
    output logic line_j,
    output logic consume,
    output logic stuff_due
);
    logic [2:0] ones;

    assign stuff_due = (ones == 3'(STUFF_RUN));
    assign consume   = step && !stuff_due;

    // Line state and run-of-ones counter.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            line_j <= 1'b1;
            ones   <= '0;
        end else if (step) begin
            if (stuff_due) begin
                line_j <= ~line_j;
                ones   <= '0;
            end else if (!data_bit) begin
                line_j <= ~line_j;
                ones   <= '0;
            end else begin
                ones   <= ones + 3'd1;
            end
        end
    end

endmodule

// File: rtl/usb_ls_tx.sv
// Low-speed USB packet transmitter (top).
// Sequences park-at-J, driver enable, coded packet, SE0, J and release.
// Commits the pending device address only when a data packet ends.
// Assumes a 12 MHz clock with BIT_CLKS = 8 for 1.5 Mb/s signalling.
module usb_ls_tx
    import usb_ls_tx_pkg::*;
#(
    parameter int BIT_CLKS = 8,
    parameter int CNT_W    = 8,
    parameter int ADDR_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              hs_sel,
    input  logic [7:0]        hs_pid,
    input  logic [CNT_W-1:0]  byte_count,
    output logic              rd_en,
    input  logic [7:0]        rd_data,
    input  logic [ADDR_W-1:0] pend_addr,
    output logic [ADDR_W-1:0] dev_addr,
    output logic              usb_dp,
    output logic              usb_dm,
    output logic              usb_oe,
    output logic              busy,
    output logic              done
);
    tx_state_e         state;
    logic              se0_half;
    logic              hs_q;
    logic              done_q;
    logic [ADDR_W-1:0] addr_q;

    logic accept;
    logic timer_run;
    logic tick;
    logic cur_bit;
    logic have_bits;
    logic line_j;
    logic consume;
    logic stuff_due;
    logic more;
    logic sym_step;

    assign accept    = start && (state == ST_IDLE);
    assign timer_run = (state == ST_LEAD) || (state == ST_DATA) ||
                       (state == ST_SE0)  || (state == ST_EOPJ);
    assign more      = have_bits || stuff_due;
    assign sym_step  = tick && ((state == ST_LEAD) || ((state == ST_DATA) && more));

    usb_ls_bit_timer #(
        .BIT_CLKS (BIT_CLKS)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (timer_run),
        .tick  (tick)
    );

    usb_ls_byte_feed #(
        .CNT_W (CNT_W)
    ) u_feed (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .hs_mode    (hs_sel),
        .hs_pid     (hs_pid),
        .byte_count (byte_count),
        .consume    (consume),
        .rd_data    (rd_data),
        .cur_bit    (cur_bit),
        .have_bits  (have_bits),
        .rd_en      (rd_en)
    );

    usb_ls_nrzi_stuff u_coder (
        .clk       (clk),
        .rst_n     (rst_n),
        .init      (accept),
        .step      (sym_step),
        .data_bit  (cur_bit),
        .line_j    (line_j),
        .consume   (consume),
        .stuff_due (stuff_due)
    );

    // Packet phase sequencer, done pulse and address commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            se0_half <= 1'b0;
            hs_q     <= 1'b0;
            done_q   <= 1'b0;
            addr_q   <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_PREP;
                        hs_q  <= hs_sel;
                    end
                end
                ST_PREP: state <= ST_LEAD;
                ST_LEAD: begin
                    if (tick) state <= ST_DATA;
                end
                ST_DATA: begin
                    if (tick && !more) begin
                        state    <= ST_SE0;
                        se0_half <= 1'b0;
                    end
                end
                ST_SE0: begin
                    if (tick) begin
                        if (se0_half) state <= ST_EOPJ;
                        else          se0_half <= 1'b1;
                    end
                end
                ST_EOPJ: begin
                    if (tick) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                        if (!hs_q) addr_q <= pend_addr;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Line pin values for each phase.
    always_comb begin
        usb_oe = timer_run;
        case (state)
            ST_PREP, ST_LEAD, ST_EOPJ: begin
                usb_dp = 1'b0;
                usb_dm = 1'b1;
            end
            ST_DATA: begin
                usb_dp = ~line_j;
                usb_dm = line_j;
            end
            default: begin
                usb_dp = 1'b0;
                usb_dm = 1'b0;
            end
        endcase
    end

    assign busy     = (state != ST_IDLE);
    assign done     = done_q;
    assign dev_addr = addr_q;

endmodule

// File: rtl/usb_ls_tx_chk.sv
// Property checker for the transmitter, attached to every instance by bind.
module usb_ls_tx_chk #(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              usb_oe,
    input logic              usb_dp,
    input logic              usb_dm,
    input logic              rd_en,
    input logic [ADDR_W-1:0] dev_addr
);
    // R2: drivers turn on only after J is already on the lines.
    a_r2_j_before_oe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(usb_oe) |-> ($past(usb_dm) && !$past(usb_dp)));

    // R4: the lines are never both high.
    a_r4_no_se1: assert property (@(posedge clk) disable iff (!rst_n)
        !(usb_dp && usb_dm));

    // R6: on release, drivers are off and both lines are low.
    a_r6_release_low: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!usb_oe && !usb_dp && !usb_dm));

    // R6: done is a single pulse that closes a busy period.
    a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    // R6: done never lasts two cycles.
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: buffer reads only inside a packet.
    a_r7_read_in_packet: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> busy);

    // R9: the active address moves only in the done cycle.
    a_r9_addr_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dev_addr) |-> done);

endmodule

bind usb_ls_tx usb_ls_tx_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .usb_oe   (usb_oe),
    .usb_dp   (usb_dp),
    .usb_dm   (usb_dm),
    .rd_en    (rd_en),
    .dev_addr (dev_addr)
);

// File: tb/usb_ls_tx_bench.sv
// Bench: a behavioural per-cycle reference built from byte queues.
module usb_ls_tx_bench;
    localparam int BIT_CLKS = 8;
    localparam int CNT_W    = 8;
    localparam int ADDR_W   = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              hs_sel = 1'b0;
    logic [7:0]        hs_pid = 8'h00;
    logic [CNT_W-1:0]  byte_count = '0;
    logic              rd_en;
    logic [7:0]        rd_data = 8'h00;
    logic [ADDR_W-1:0] pend_addr = '0;
    logic [ADDR_W-1:0] dev_addr;
    logic              usb_dp, usb_dm, usb_oe, busy, done;

    always #5 clk = ~clk;

    usb_ls_tx #(.BIT_CLKS(BIT_CLKS), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_usb_ls_tx (
        .clk(clk), .rst_n(rst_n), .start(start), .hs_sel(hs_sel), .hs_pid(hs_pid),
        .byte_count(byte_count), .rd_en(rd_en), .rd_data(rd_data),
        .pend_addr(pend_addr), .dev_addr(dev_addr), .usb_dp(usb_dp),
        .usb_dm(usb_dm), .usb_oe(usb_oe), .busy(busy), .done(done)
    );

    // Buffer model: registered read, one byte per strobe.
    logic [7:0] mem [0:1023];
    int         rd_tot = 0;
    always @(posedge clk) begin
        if (rd_en) begin
            rd_data <= mem[rd_tot];
            rd_tot  <= rd_tot + 1;
        end
    end

    typedef struct {
        logic [4:0] v;     // {oe, dp, dm, busy, done}
        string      tag;
    } exp_t;

    exp_t       eq[$];
    logic [7:0] payload[$];
    int         total = 0;
    int         bad = 0;
    int         cyc = 0;
    int         rd_base = 0;
    logic [ADDR_W-1:0] exp_addr = '0;

    task automatic check(input bit ok, input string tag, input int got, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s at cycle %0d: got=%0h expected=%0h", tag, cyc, got, exp);
        end
    endtask

    task automatic push(input logic [4:0] v, input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.v = v;
            e.tag = tag;
            eq.push_back(e);
        end
    endtask

    // One clock: compare at the falling edge, then drop start.
    task automatic step();
        exp_t e;
        logic [4:0] got;
        @(negedge clk);
        cyc++;
        got = {usb_oe, usb_dp, usb_dm, busy, done};
        if (eq.size() > 0) e = eq.pop_front();
        else begin
            e.v = 5'b00000;
            e.tag = "R10 idle";
        end
        check(got === e.v, e.tag, int'(got), int'(e.v));
        start = 1'b0;
    endtask

    // Request a packet and queue its predicted waveform.
    task automatic launch(input bit hs, input logic [7:0] pid, input int cnt);
        logic [7:0] bytes[$];
        logic line;
        int ones;
        bytes.push_back(8'h80);
        if (hs) bytes.push_back(pid);
        else begin
            for (int i = 0; i < cnt - 1; i++) begin
                mem[rd_tot + i] = payload[i];
                bytes.push_back(payload[i]);
            end
            exp_addr = pend_addr;
        end
        rd_base = rd_tot;
        start = 1'b1;
        hs_sel = hs;
        hs_pid = pid;
        byte_count = CNT_W'(cnt);
        push(5'b00110, "R2 park J", 1);
        push(5'b10110, "R2 lead J", BIT_CLKS);
        line = 1'b1;
        ones = 0;
        for (int b = 0; b < bytes.size(); b++) begin
            for (int k = 0; k < 8; k++) begin
                if (bytes[b][k]) ones++;
                else begin
                    line = ~line;
                    ones = 0;
                end
                push({1'b1, ~line, line, 2'b10}, (b == 0) ? "R3 sync" : "R4 data", BIT_CLKS);
                if (ones == 6) begin
                    line = ~line;
                    ones = 0;
                    push({1'b1, ~line, line, 2'b10}, "R5 stuff", BIT_CLKS);
                end
            end
        end
        push(5'b10010, "R6 SE0", 2 * BIT_CLKS);
        push(5'b10110, "R6 end J", BIT_CLKS);
        push(5'b00001, "R6 release", 1);
    endtask

    task automatic run_out();
        int guard = 0;
        while (eq.size() > 0 && guard < 20000) begin
            step();
            guard++;
        end
        if (eq.size() > 0) begin
            check(1'b0, "watchdog", int'(eq.size()), 0);
            eq.delete();
        end
    endtask

    initial begin
        // R1: reset state.
        repeat (3) step();
        check({usb_oe, usb_dp, usb_dm, busy, done, rd_en} == 6'b0, "R1 pins", 0, 0);
        check(dev_addr == '0, "R1 addr", int'(dev_addr), 0);
        rst_n = 1'b1;
        step();

        // R4/R7/R9: mixed payload, address committed.
        payload = '{8'hC3, 8'h55, 8'h00};
        pend_addr = 7'h15;
        launch(1'b0, 8'h00, 4);
        run_out();
        check(rd_tot - rd_base == 3, "R7 read count", rd_tot - rd_base, 3);
        check(dev_addr == exp_addr, "R9 data commit", int'(dev_addr), int'(exp_addr));

        // R5: ones crossing a byte boundary.
        payload = '{8'hFF, 8'hFF};
        launch(1'b0, 8'h00, 3);
        run_out();
        check(rd_tot - rd_base == 2, "R7 read count", rd_tot - rd_base, 2);

        // R5: a run of six closing the packet.
        payload = '{8'hFC};
        launch(1'b0, 8'h00, 2);
        run_out();

        // R8/R9: handshake ignores count and buffer, address unchanged.
        pend_addr = 7'h6B;
        launch(1'b1, 8'hD2, 9);
        run_out();
        check(rd_tot - rd_base == 0, "R8 no reads", rd_tot - rd_base, 0);
        check(dev_addr == 7'h15, "R9 handshake keeps", int'(dev_addr), 'h15);

        // R10: start while busy is ignored.
        payload = '{8'h3C, 8'h81};
        pend_addr = 7'h2A;
        launch(1'b0, 8'h00, 3);
        repeat (40) step();
        check(busy == 1'b1, "R10 busy mid", int'(busy), 1);
        start = 1'b1;
        hs_sel = 1'b1;
        run_out();
        check(dev_addr == 7'h2A, "R9 data commit", int'(dev_addr), 'h2A);

        // R11: a new start in the done cycle.
        payload = '{8'h01};
        launch(1'b0, 8'h00, 2);
        while (eq.size() > 1) step();
        step();
        begin
            int bad0 = bad;
            payload = '{8'hA5, 8'hFE};
            pend_addr = 7'h33;
            launch(1'b0, 8'h00, 3);
            run_out();
            check(bad == bad0, "R11 back-to-back", bad - bad0, 0);
        end
        check(dev_addr == 7'h33, "R9 data commit", int'(dev_addr), 'h33);

        // R7: sync-only packet.
        launch(1'b0, 8'h00, 1);
        run_out();
        check(rd_tot - rd_base == 0, "R7 sync only", rd_tot - rd_base, 0);
        repeat (4) step();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule